// File: doc/BRIEF.md
# Time-of-Day Access Command Controller

This block is the command front end through which host software reaches a set of free-running time domains. It sits between a simple write port and an attached time counter, and the block owns one access slot. The host stages seconds and nanoseconds in three data registers, then writes an action code with a domain number. The block turns that action into a held request on the counter's load, snapshot or delta port, and keeps that request until the counter acknowledges.

An absolute load or a signed delta is only honoured directly after an idle action, so every time change needs an explicit idle, stage, apply sequence. A snapshot copies the selected domain's time into the data registers in a single cycle, and the host then reads it back from the register outputs. Actions that belong to other machinery are decoded and then dropped. Requests that break the sequencing rules raise a sticky error flag.

Top module: `tod_access_ctrl`

## Requirements
- R1: After reset, busy, errFlag and all three request outputs are low and the three data registers read zero.
- R2: An action write is accepted only when cmdSlot equals ACCESS_SLOT (default 5). A write that names any other slot changes nothing.
- R3: Action codes are 0 idle, 1 load, 2 save, 3 clock-out, 4 delta, 5 tod-out. Codes 3, 5, 6 and 7 raise no request, leave busy low and leave errFlag unchanged. Like every accepted non-idle code, they end the idle phase.
- R4: A load (code 1) is carried out only when the previously accepted action was idle (code 0). It requests a load of the selected domain with tcSec = {seconds-high, seconds-low} and tcNs = the nanoseconds register.
- R5: A load or delta that does not follow an idle, or any load, save or delta whose cmdDomain is NUM_DOMAINS (default 3) or higher, raises no request and sets errFlag. errFlag then stays high until reset.
- R6: busy rises in the cycle after an accepted load, save or delta, and falls at the first clock edge that samples tcAck high. Over that window exactly one of tcLoad, tcSave and tcDelta is high, and that request, its domain and its operands are held steady. With a counter that acknowledges on its third request cycle, busy is seen high for 3 cycles.
- R7: A save (code 2) copies tcSnapSec and tcSnapNs into the data registers at the acknowledging edge, all three fields from that one cycle. This copy takes priority over a host data write in the same cycle.
- R8: A delta (code 4), issued after an idle, requests tcDelta for the selected domain with tcNs carrying the nanoseconds register as a two's-complement signed correction. For example, 30'h3FFFFFFB means -5 ns.
- R9: While busy is high, data-register writes and action writes are ignored.
- R10: With busy low, a data write with datSel 0 (seconds-high), 1 (seconds-low) or 2 (nanoseconds) updates that register, and the new value is visible on the read outputs in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdWrEn | input | 1 | Action write strobe |
| cmdSlot | input | SLOT_W | Access slot addressed by the action write |
| cmdAction | input | 3 | Action code |
| cmdDomain | input | DOM_W | Target time domain |
| cmdSync | input | 1 | Sync flag forwarded with the request |
| datWrEn | input | 1 | Data register write strobe |
| datSel | input | 2 | Data register select: 0 sec-high, 1 sec-low, 2 ns |
| datWrData | input | DATA_W | Data register write value |
| rdSecHi | output | SEC_HI_W | Seconds-high register |
| rdSecLo | output | SEC_LO_W | Seconds-low register |
| rdNs | output | NS_W | Nanoseconds register |
| busy | output | 1 | Operation in flight |
| errFlag | output | 1 | Sticky sequencing or domain error |
| tcLoad | output | 1 | Absolute load request to the counter |
| tcSave | output | 1 | Snapshot request to the counter |
| tcDelta | output | 1 | Signed delta request to the counter |
| tcDomain | output | DOM_W | Domain of the pending request |
| tcSync | output | 1 | Sync flag of the pending request |
| tcSec | output | SEC_HI_W+SEC_LO_W | Seconds operand for a load |
| tcNs | output | NS_W | Nanoseconds operand or signed delta |
| tcAck | input | 1 | Counter acknowledge of the pending request |
| tcSnapSec | input | SEC_HI_W+SEC_LO_W | Seconds of the requested domain |
| tcSnapNs | input | NS_W | Nanoseconds of the requested domain |

## Verification
Two things can fall in the same cycle: the counter's acknowledge of a snapshot and a host write to a data register. The bench waits for its counter model to raise tcAck and drives a nanoseconds write during that cycle. It then judges that all three registers hold the snapshot and not the host value. A second collision puts an action write in a cycle that is still busy. The bench follows it with a load, which must be refused because the earlier idle was never accepted.

// File: rtl/tod_acc_pkg.sv
package tod_acc_pkg;

  typedef enum logic [2:0] {
    ACT_IDLE  = 3'd0,
    ACT_LOAD  = 3'd1,
    ACT_SAVE  = 3'd2,
    ACT_CLOCK = 3'd3,
    ACT_DELTA = 3'd4,
    ACT_TOD   = 3'd5
  } action_e;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_LOAD  = 2'd1,
    OP_SAVE  = 2'd2,
    OP_DELTA = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    SEL_SEC_HI = 2'd0,
    SEL_SEC_LO = 2'd1,
    SEL_NS     = 2'd2
  } datSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic captureSnap;
    logic hostWrOk;
  } dpCtrl_t;

endpackage

// File: rtl/tod_acc_ctrl.sv
module tod_acc_ctrl
  import tod_acc_pkg::*;
#(
  parameter int NUM_DOMAINS = 3,
  parameter int DOM_W       = 2,
  parameter int SLOT_W      = 3,
  parameter int ACCESS_SLOT = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdWrEn,
  input  logic [SLOT_W-1:0] cmdSlot,
  input  logic [2:0]        cmdAction,
  input  logic [DOM_W-1:0]  cmdDomain,
  input  logic              cmdSync,
  input  logic              tcAck,
  output logic              busy,
  output logic              errFlag,
  output logic              tcLoad,
  output logic              tcSave,
  output logic              tcDelta,
  output logic [DOM_W-1:0]  tcDomain,
  output logic              tcSync,
  output dpCtrl_t           dpCtrl
);

  localparam logic [SLOT_W-1:0] MY_SLOT   = SLOT_W'(ACCESS_SLOT);
  localparam logic [DOM_W:0]    DOM_LIMIT = (DOM_W + 1)'(NUM_DOMAINS);

  logic             busyQ;
  op_e              opQ;
  logic [DOM_W-1:0] domQ;
  logic             syncQ;
  logic             prevIdleQ;
  logic             errQ;

  logic accept;
  logic domOk;
  logic ackNow;

  assign accept = cmdWrEn && (cmdSlot == MY_SLOT) && !busyQ;
  assign domOk  = ({1'b0, cmdDomain} < DOM_LIMIT);
  assign ackNow = busyQ && tcAck;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ     <= 1'b0;
      opQ       <= OP_NONE;
      domQ      <= '0;
      syncQ     <= 1'b0;
      prevIdleQ <= 1'b0;
      errQ      <= 1'b0;
    end else begin
      if (ackNow) begin
        busyQ <= 1'b0;
        opQ   <= OP_NONE;
      end
      if (accept) begin
        prevIdleQ <= (cmdAction == ACT_IDLE);
        case (cmdAction)
          ACT_LOAD, ACT_DELTA: begin
            if (prevIdleQ && domOk) begin
              busyQ <= 1'b1;
              opQ   <= (cmdAction == ACT_LOAD) ? OP_LOAD : OP_DELTA;
              domQ  <= cmdDomain;
              syncQ <= cmdSync;
            end else begin
              errQ <= 1'b1;
            end
          end
          ACT_SAVE: begin
            if (domOk) begin
              busyQ <= 1'b1;
              opQ   <= OP_SAVE;
              domQ  <= cmdDomain;
              syncQ <= cmdSync;
            end else begin
              errQ <= 1'b1;
            end
          end
          default: ; // idle, clock-out, tod-out and unused codes: no request
        endcase
      end
    end
  end

  always_comb begin
    busy     = busyQ;
    errFlag  = errQ;
    tcLoad   = busyQ && (opQ == OP_LOAD);
    tcSave   = busyQ && (opQ == OP_SAVE);
    tcDelta  = busyQ && (opQ == OP_DELTA);
    tcDomain = domQ;
    tcSync   = syncQ;
    dpCtrl.captureSnap = ackNow && (opQ == OP_SAVE);
    dpCtrl.hostWrOk    = !busyQ;
  end

endmodule

// File: rtl/tod_acc_dp.sv
module tod_acc_dp
  import tod_acc_pkg::*;
#(
  parameter int SEC_HI_W = 16,
  parameter int SEC_LO_W = 32,
  parameter int NS_W     = 30,
  parameter int DATA_W   = 32,
  localparam int SEC_W   = SEC_HI_W + SEC_LO_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpCtrl_t             dpCtrl,
  input  logic                datWrEn,
  input  logic [1:0]          datSel,
  input  logic [DATA_W-1:0]   datWrData,
  input  logic [SEC_W-1:0]    tcSnapSec,
  input  logic [NS_W-1:0]     tcSnapNs,
  output logic [SEC_HI_W-1:0] rdSecHi,
  output logic [SEC_LO_W-1:0] rdSecLo,
  output logic [NS_W-1:0]     rdNs,
  output logic [SEC_W-1:0]    tcSec,
  output logic [NS_W-1:0]     tcNs
);

  logic [SEC_HI_W-1:0] secHiQ;
  logic [SEC_LO_W-1:0] secLoQ;
  logic [NS_W-1:0]     nsQ;
  logic                hostWr;

  assign hostWr = datWrEn && dpCtrl.hostWrOk;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      secHiQ <= '0;
      secLoQ <= '0;
      nsQ    <= '0;
    end else if (dpCtrl.captureSnap) begin
      secHiQ <= tcSnapSec[SEC_W-1:SEC_LO_W];
      secLoQ <= tcSnapSec[SEC_LO_W-1:0];
      nsQ    <= tcSnapNs;
    end else if (hostWr) begin
      case (datSel)
        SEL_SEC_HI: secHiQ <= datWrData[SEC_HI_W-1:0];
        SEL_SEC_LO: secLoQ <= datWrData[SEC_LO_W-1:0];
        SEL_NS:     nsQ    <= datWrData[NS_W-1:0];
        default: ;
      endcase
    end
  end

  assign rdSecHi = secHiQ;
  assign rdSecLo = secLoQ;
  assign rdNs    = nsQ;
  assign tcSec   = {secHiQ, secLoQ};
  assign tcNs    = nsQ;

endmodule

// File: rtl/tod_access_ctrl.sv
module tod_access_ctrl
  import tod_acc_pkg::*;
#(
  parameter int NUM_DOMAINS = 3,
  parameter int SLOT_W      = 3,
  parameter int ACCESS_SLOT = 5,
  parameter int SEC_HI_W    = 16,
  parameter int SEC_LO_W    = 32,
  parameter int NS_W        = 30,
  parameter int DATA_W      = 32,
  localparam int DOM_W      = (NUM_DOMAINS > 1) ? $clog2(NUM_DOMAINS) : 1,
  localparam int SEC_W      = SEC_HI_W + SEC_LO_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cmdWrEn,
  input  logic [SLOT_W-1:0]   cmdSlot,
  input  logic [2:0]          cmdAction,
  input  logic [DOM_W-1:0]    cmdDomain,
  input  logic                cmdSync,
  input  logic                datWrEn,
  input  logic [1:0]          datSel,
  input  logic [DATA_W-1:0]   datWrData,
  output logic [SEC_HI_W-1:0] rdSecHi,
  output logic [SEC_LO_W-1:0] rdSecLo,
  output logic [NS_W-1:0]     rdNs,
  output logic                busy,
  output logic                errFlag,
  output logic                tcLoad,
  output logic                tcSave,
  output logic                tcDelta,
  output logic [DOM_W-1:0]    tcDomain,
  output logic                tcSync,
  output logic [SEC_W-1:0]    tcSec,
  output logic [NS_W-1:0]     tcNs,
  input  logic                tcAck,
  input  logic [SEC_W-1:0]    tcSnapSec,
  input  logic [NS_W-1:0]     tcSnapNs
);

  dpCtrl_t dpCtrl;

  tod_acc_ctrl #(
    .NUM_DOMAINS(NUM_DOMAINS),
    .DOM_W      (DOM_W),
    .SLOT_W     (SLOT_W),
    .ACCESS_SLOT(ACCESS_SLOT)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdWrEn  (cmdWrEn),
    .cmdSlot  (cmdSlot),
    .cmdAction(cmdAction),
    .cmdDomain(cmdDomain),
    .cmdSync  (cmdSync),
    .tcAck    (tcAck),
    .busy     (busy),
    .errFlag  (errFlag),
    .tcLoad   (tcLoad),
    .tcSave   (tcSave),
    .tcDelta  (tcDelta),
    .tcDomain (tcDomain),
    .tcSync   (tcSync),
    .dpCtrl   (dpCtrl)
  );

  tod_acc_dp #(
    .SEC_HI_W(SEC_HI_W),
    .SEC_LO_W(SEC_LO_W),
    .NS_W    (NS_W),
    .DATA_W  (DATA_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .dpCtrl   (dpCtrl),
    .datWrEn  (datWrEn),
    .datSel   (datSel),
    .datWrData(datWrData),
    .tcSnapSec(tcSnapSec),
    .tcSnapNs (tcSnapNs),
    .rdSecHi  (rdSecHi),
    .rdSecLo  (rdSecLo),
    .rdNs     (rdNs),
    .tcSec    (tcSec),
    .tcNs     (tcNs)
  );

endmodule

// File: rtl/tod_acc_chk.sv
module tod_acc_chk #(
  parameter int SLOT_W      = 3,
  parameter int ACCESS_SLOT = 5,
  parameter int DOM_W       = 2,
  parameter int SEC_HI_W    = 16,
  parameter int SEC_LO_W    = 32,
  parameter int NS_W        = 30
) (
  input logic                         clk,
  input logic                         rstN,
  input logic                         cmdWrEn,
  input logic [SLOT_W-1:0]            cmdSlot,
  input logic                         busy,
  input logic                         errFlag,
  input logic                         tcLoad,
  input logic                         tcSave,
  input logic                         tcDelta,
  input logic [DOM_W-1:0]             tcDomain,
  input logic                         tcSync,
  input logic [SEC_HI_W+SEC_LO_W-1:0] tcSec,
  input logic [NS_W-1:0]              tcNs,
  input logic                         tcAck,
  input logic [SEC_HI_W+SEC_LO_W-1:0] tcSnapSec,
  input logic [NS_W-1:0]              tcSnapNs,
  input logic [SEC_HI_W-1:0]          rdSecHi,
  input logic [SEC_LO_W-1:0]          rdSecLo,
  input logic [NS_W-1:0]              rdNs
);

  localparam logic [SLOT_W-1:0] MY_SLOT = SLOT_W'(ACCESS_SLOT);

  // R6
  req_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({tcLoad, tcSave, tcDelta}));

  // R6
  busy_req_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy == (tcLoad || tcSave || tcDelta));

  // R6
  ack_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy && tcAck |=> !busy);

  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy && !tcAck |=> busy && $stable({tcLoad, tcSave, tcDelta, tcDomain, tcSync, tcSec, tcNs}));

  // R5
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);

  // R7
  snap_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    tcSave && tcAck |=> ({rdSecHi, rdSecLo} == $past(tcSnapSec)) && (rdNs == $past(tcSnapNs)));

  // R9
  busy_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy && !tcAck |=> $stable({rdSecHi, rdSecLo, rdNs}));

  // R2
  wrong_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy && cmdWrEn && (cmdSlot != MY_SLOT) |=> !busy && $stable(errFlag));

endmodule

bind tod_access_ctrl tod_acc_chk #(
  .SLOT_W     (SLOT_W),
  .ACCESS_SLOT(ACCESS_SLOT),
  .DOM_W      (DOM_W),
  .SEC_HI_W   (SEC_HI_W),
  .SEC_LO_W   (SEC_LO_W),
  .NS_W       (NS_W)
) u_chk (.*);

// File: tb/sim_tod_access_ctrl.sv
module sim_tod_access_ctrl;

  localparam int LAT = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdWrEn = 1'b0;
  logic [2:0]  cmdSlot = 3'd5;
  logic [2:0]  cmdAction = 3'd0;
  logic [1:0]  cmdDomain = 2'd0;
  logic        cmdSync = 1'b0;
  logic        datWrEn = 1'b0;
  logic [1:0]  datSel = 2'd0;
  logic [31:0] datWrData = 32'd0;
  logic [15:0] rdSecHi;
  logic [31:0] rdSecLo;
  logic [29:0] rdNs;
  logic        busy, errFlag, tcLoad, tcSave, tcDelta, tcSync, tcAck;
  logic [1:0]  tcDomain;
  logic [47:0] tcSec, tcSnapSec;
  logic [29:0] tcNs, tcSnapNs;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tod_access_ctrl u0 (.*);

  // counter model: three static time domains, ack on the third request cycle
  logic [47:0] mSec [3];
  logic [29:0] mNs  [3];
  int cnt = 0;
  logic anyReq;
  assign anyReq    = tcLoad | tcSave | tcDelta;
  assign tcAck     = anyReq && (cnt == LAT - 1);
  assign tcSnapSec = (tcDomain < 2'd3) ? mSec[tcDomain] : 48'd0;
  assign tcSnapNs  = (tcDomain < 2'd3) ? mNs[tcDomain]  : 30'd0;

  initial begin
    mSec[0] = 48'd0;            mNs[0] = 30'd0;
    mSec[1] = 48'h0000_0000_0011; mNs[1] = 30'd500;
    mSec[2] = 48'h0000_0000_00A0; mNs[2] = 30'd3;
  end

  always @(posedge clk) begin
    if (!rstN) cnt <= 0;
    else if (tcAck) begin
      cnt <= 0;
      if (tcLoad) begin
        mSec[tcDomain] <= tcSec;
        mNs[tcDomain]  <= tcNs;
      end
      if (tcDelta) begin
        longint t;
        t = longint'(mNs[tcDomain]) + longint'($signed(tcNs));
        if (t < 0) begin
          mSec[tcDomain] <= mSec[tcDomain] - 48'd1;
          mNs[tcDomain]  <= 30'(t + 1000000000);
        end else if (t >= 1000000000) begin
          mSec[tcDomain] <= mSec[tcDomain] + 48'd1;
          mNs[tcDomain]  <= 30'(t - 1000000000);
        end else begin
          mNs[tcDomain] <= 30'(t);
        end
      end
    end else if (anyReq) cnt <= cnt + 1;
  end

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic action(logic [2:0] a, logic [1:0] d, logic [2:0] slot = 3'd5);
    cmdWrEn = 1'b1; cmdAction = a; cmdDomain = d; cmdSlot = slot; cmdSync = d[0];
    @(negedge clk);
    cmdWrEn = 1'b0;
  endtask

  task automatic dat(logic [1:0] sel, logic [31:0] v);
    datWrEn = 1'b1; datSel = sel; datWrData = v;
    @(negedge clk);
    datWrEn = 1'b0;
  endtask

  task automatic waitIdle(output int cycles);
    cycles = 0;
    while (busy && cycles < 50) begin
      @(negedge clk);
      cycles++;
    end
  endtask

  task automatic t_reset();
    chk("R1", "busy", 64'(busy), 64'd0);
    chk("R1", "errFlag", 64'(errFlag), 64'd0);
    chk("R1", "requests", 64'({tcLoad, tcSave, tcDelta}), 64'd0);
    chk("R1", "data regs", 64'({rdSecHi, rdSecLo} | 48'(rdNs)), 64'd0);
  endtask

  task automatic t_dataRegs();
    dat(2'd0, 32'h0000_1234);
    chk("R10", "sec hi", 64'(rdSecHi), 64'h1234);
    dat(2'd1, 32'hDEAD_BEEF);
    chk("R10", "sec lo", 64'(rdSecLo), 64'hDEAD_BEEF);
    dat(2'd2, 32'd123456789);
    chk("R10", "ns", 64'(rdNs), 64'd123456789);
  endtask

  task automatic t_load();
    int c;
    action(3'd0, 2'd0);
    dat(2'd0, 32'h0000_0042);
    dat(2'd1, 32'h1111_2222);
    dat(2'd2, 32'd777);
    action(3'd1, 2'd1);
    chk("R4", "tcLoad", 64'({tcLoad, tcSave, tcDelta}), 64'b100);
    chk("R4", "tcDomain", 64'(tcDomain), 64'd1);
    chk("R4", "tcSec", 64'(tcSec), 64'h0042_1111_2222);
    chk("R4", "tcNs", 64'(tcNs), 64'd777);
    waitIdle(c);
    chk("R6", "busy cycles", 64'(c), 64'(LAT));
    chk("R4", "domain1 sec", 64'(mSec[1]), 64'h0042_1111_2222);
    chk("R4", "domain1 ns", 64'(mNs[1]), 64'd777);
  endtask

  task automatic t_loadNoIdle();
    action(3'd1, 2'd1);
    chk("R5", "load w/o idle busy", 64'(busy), 64'd0);
    chk("R5", "load w/o idle err", 64'(errFlag), 64'd1);
    action(3'd0, 2'd0);
    @(negedge clk);
    chk("R5", "err sticky", 64'(errFlag), 64'd1);
    doReset();
    chk("R5", "err cleared by reset", 64'(errFlag), 64'd0);
  endtask

  task automatic t_save();
    int c;
    action(3'd2, 2'd1);
    chk("R6", "tcSave", 64'({tcLoad, tcSave, tcDelta}), 64'b010);
    waitIdle(c);
    chk("R7", "save sec", 64'({rdSecHi, rdSecLo}), 64'h0042_1111_2222);
    chk("R7", "save ns", 64'(rdNs), 64'd777);
  endtask

  task automatic t_delta();
    int c;
    action(3'd0, 2'd0);
    dat(2'd2, 32'h3FFF_FFFB);
    action(3'd4, 2'd2);
    chk("R8", "tcDelta", 64'({tcLoad, tcSave, tcDelta}), 64'b001);
    chk("R8", "tcNs signed", 64'(tcNs), 64'h3FFF_FFFB);
    waitIdle(c);
    action(3'd2, 2'd2);
    waitIdle(c);
    chk("R8", "delta result sec", 64'({rdSecHi, rdSecLo}), 64'h9F);
    chk("R8", "delta result ns", 64'(rdNs), 64'd999999998);
  endtask

  task automatic t_slot();
    int c;
    action(3'd0, 2'd0);
    action(3'd1, 2'd0, 3'd4);
    chk("R2", "wrong slot busy", 64'(busy), 64'd0);
    chk("R2", "wrong slot err", 64'(errFlag), 64'd0);
    action(3'd1, 2'd0);
    chk("R2", "right slot load", 64'(tcLoad), 64'd1);
    waitIdle(c);
  endtask

  task automatic t_busyIgnore();
    int c;
    action(3'd0, 2'd0);
    dat(2'd2, 32'd1000);
    action(3'd1, 2'd0);
    dat(2'd2, 32'd55);
    action(3'd0, 2'd0);
    chk("R9", "operand held", 64'(tcNs), 64'd1000);
    waitIdle(c);
    chk("R9", "ns write ignored", 64'(rdNs), 64'd1000);
    action(3'd1, 2'd0);
    chk("R9", "idle while busy ignored", 64'(errFlag), 64'd1);
    doReset();
  endtask

  task automatic t_noop();
    action(3'd0, 2'd0);
    action(3'd3, 2'd0);
    chk("R3", "clock-out", 64'({busy, tcLoad, tcSave, tcDelta, errFlag}), 64'd0);
    action(3'd5, 2'd1);
    chk("R3", "tod-out", 64'({busy, tcLoad, tcSave, tcDelta, errFlag}), 64'd0);
    action(3'd7, 2'd1);
    chk("R3", "code 7", 64'({busy, tcLoad, tcSave, tcDelta, errFlag}), 64'd0);
    action(3'd1, 2'd0);
    chk("R3", "no-op ends idle", 64'({busy, errFlag}), 64'b01);
    doReset();
  endtask

  task automatic t_domain();
    action(3'd0, 2'd0);
    action(3'd1, 2'd3);
    chk("R5", "domain 3 load", 64'({busy, errFlag}), 64'b01);
    doReset();
    action(3'd2, 2'd3);
    chk("R5", "domain 3 save", 64'({busy, errFlag}), 64'b01);
    doReset();
  endtask

  task automatic t_sameCycle();
    int c;
    action(3'd2, 2'd2);
    c = 0;
    while (!tcAck && c < 20) begin @(negedge clk); c++; end
    dat(2'd2, 32'd55);
    chk("R7", "released after ack", 64'(busy), 64'd0);
    chk("R7", "capture beats write sec", 64'({rdSecHi, rdSecLo}), 64'h9F);
    chk("R7", "capture beats write ns", 64'(rdNs), 64'd999999998);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_dataRegs();
    t_load();
    t_loadNoIdle();
    t_save();
    t_delta();
    t_slot();
    t_busyIgnore();
    t_noop();
    t_domain();
    t_sameCycle();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule